// File: doc/BRIEF.md
# Fine-Grained Thread Issue Selector

The selector decides, in every clock cycle, which hardware thread context feeds the next instruction into a shared single-issue pipeline. A thread is a candidate when its ready flag is high and its stall flag is low. The pick is combinational from the present inputs and two pieces of registered state: a rotation pointer and a small configuration (policy and favoured thread). The pick is presented as a one-hot grant, an encoded index and a valid flag. Instructions from different threads therefore interleave cycle by cycle, and stalled contexts are passed over.

Two policies exist. Under rotation, the search starts at the pointer and takes the first candidate in ascending, wrapping order. After each grant the pointer moves to the thread after the winner, so a thread that could issue every cycle still cedes slots to its peers. Under the favoured-thread policy, the favoured context wins whenever it is a candidate. The rotation search serves the others only while it cannot issue. The policy and favoured index are loaded by a configuration write and govern selection from the following cycle on.

Top module: `thread_issue_sel`

## Requirements
- R1: After reset the pointer is 0 and the policy is rotation, so with all threads candidates the first grant goes to thread 0.
- R2: grant_vld is high exactly when at least one thread has ready=1 and stall=0. grant_oh has bit grant_idx set and no other bit when valid, and is all zeros otherwise.
- R3: A thread whose stall bit is 1 or whose ready bit is 0 is never granted.
- R4: Under rotation the grant is the first candidate found from the pointer upward. After any grant the pointer becomes the granted index plus one.
- R5: Under rotation a thread that stays a candidate waits at most N_THR-1 cycles between grants. It yields to other candidates even though it is ready every cycle.
- R6: Under the favoured-thread policy (cfg_mode=1), the favoured thread is granted in every cycle in which it is a candidate.
- R7: Under the favoured-thread policy, while the favoured thread is not a candidate, the others are granted in rotation order from the pointer.
- R8: When no thread is a candidate, grant_vld=0, grant_oh=0 and grant_idx=0, and the pointer keeps its value. The next grant then starts its search where the last one left off.
- R9: A configuration write (cfg_wr=1, cfg_mode 0=rotation 1=favoured, cfg_pref=index) is captured at the clock edge. The cycle of the write still selects with the old configuration.
- R10: The pointer wraps from thread N_THR-1 to thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_ready | input | N_THR | Per-thread has-instruction flag |
| thr_stall | input | N_THR | Per-thread stalled flag |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_mode | input | 1 | 0 rotation, 1 favoured thread |
| cfg_pref | input | IDX_W | Favoured thread index |
| grant_oh | output | N_THR | One-hot granted thread |
| grant_idx | output | IDX_W | Encoded granted thread |
| grant_vld | output | 1 | A thread was granted this cycle |

## Verification
The bench targets the pointer's behaviour around gaps. After a cycle with no candidate, a design that reset or advanced its pointer would restart the search at the wrong thread. At the top index, a pointer that failed to wrap would skip thread 0. A mixed stall/ready pattern catches a design that looked only at one of the two flags and granted a stalled context. The configuration tests check the write cycle itself: a design that applied the new policy combinationally would hand the favoured thread a slot one cycle early. A design that kept favouring a stalled favourite, or that failed to rotate the others around it, shows up as wrong indices while the favourite is stalled. A randomised stall run measures the longest wait of one always-ready thread and exposes any starvation.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    typedef enum logic {
        POL_ROTATE = 1'b0,
        POL_PREFER = 1'b1
    } policy_e;

    typedef struct packed {
        policy_e    mode;
        logic [7:0] pref;
    } tsel_cfg_t;

    function automatic int unsigned wrap_next(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/tsel_cfg_reg.sv
module tsel_cfg_reg
    import tsel_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  policy_e          mode_in,
    input  logic [IDX_W-1:0] pref_in,
    output policy_e          mode_q,
    output logic [IDX_W-1:0] pref_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= POL_ROTATE;
            pref_q <= '0;
        end else if (wr_en) begin
            mode_q <= mode_in;
            pref_q <= pref_in;
        end
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mode_q == $past(mode_in)) && (pref_q == $past(pref_in))); // R9
    AST_CFG_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mode_q) && $stable(pref_q)); // R9

endmodule

// File: rtl/tsel_pick.sv
module tsel_pick
    import tsel_pkg::*;
#(
    parameter int N_THR = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_THR-1:0] elig,
    input  logic [IDX_W-1:0] ptr,
    input  policy_e          mode,
    input  logic [IDX_W-1:0] pref,
    output logic [N_THR-1:0] oh,
    output logic [IDX_W-1:0] idx,
    output logic             vld
);

    logic pref_hit;

    always_comb begin
        pref_hit = 1'b0;
        if (mode == POL_PREFER && int'(pref) < N_THR)
            pref_hit = elig[pref];
    end

    always_comb begin
        logic found;
        logic [IDX_W-1:0] sel;
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < N_THR; k++) begin
            int c;
            c = int'(ptr) + k;
            if (c >= N_THR) c = c - N_THR;
            if (!found && elig[c]) begin
                found = 1'b1;
                sel   = c[IDX_W-1:0];
            end
        end
        if (pref_hit) begin
            found = 1'b1;
            sel   = pref;
        end
        vld = found;
        idx = sel;
        oh  = found ? (N_THR'(1) << sel) : '0;
    end

    AST_PREF_FIRST: assert property (@(posedge clk) disable iff (rst)
        (mode == POL_PREFER && int'(pref) < N_THR && elig[pref]) |-> (idx == pref)); // R6
    AST_ROT_AT_PTR: assert property (@(posedge clk) disable iff (rst)
        (mode == POL_ROTATE && elig[ptr]) |-> (idx == ptr)); // R4

endmodule

// File: rtl/tsel_ptr.sv
module tsel_ptr
    import tsel_pkg::*;
#(
    parameter int N_THR = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [IDX_W-1:0] won_idx,
    output logic [IDX_W-1:0] ptr_q
);

    logic [IDX_W-1:0] nxt;

    always_comb begin
        int unsigned w;
        w   = wrap_next(int'(won_idx), N_THR);
        nxt = w[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)      ptr_q <= '0;
        else if (adv) ptr_q <= nxt;
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ptr_q)); // R8
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && int'(won_idx) == N_THR - 1) |=> (ptr_q == '0)); // R10

endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel
    import tsel_pkg::*;
#(
    parameter int N_THR = 4,
    localparam int IDX_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_THR-1:0] thr_ready,
    input  logic [N_THR-1:0] thr_stall,
    input  logic             cfg_wr,
    input  logic             cfg_mode,
    input  logic [IDX_W-1:0] cfg_pref,
    output logic [N_THR-1:0] grant_oh,
    output logic [IDX_W-1:0] grant_idx,
    output logic             grant_vld
);

    logic [N_THR-1:0] elig;
    policy_e          mode_q;
    logic [IDX_W-1:0] pref_q;
    logic [IDX_W-1:0] ptr_q;

    assign elig = thr_ready & ~thr_stall;

    tsel_cfg_reg #(.IDX_W(IDX_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .mode_in (policy_e'(cfg_mode)),
        .pref_in (cfg_pref),
        .mode_q  (mode_q),
        .pref_q  (pref_q)
    );

    tsel_pick #(.N_THR(N_THR), .IDX_W(IDX_W)) u_pick (
        .clk  (clk),
        .rst  (rst),
        .elig (elig),
        .ptr  (ptr_q),
        .mode (mode_q),
        .pref (pref_q),
        .oh   (grant_oh),
        .idx  (grant_idx),
        .vld  (grant_vld)
    );

    tsel_ptr #(.N_THR(N_THR), .IDX_W(IDX_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .adv     (grant_vld),
        .won_idx (grant_idx),
        .ptr_q   (ptr_q)
    );

    AST_GRANT_SHAPE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_oh) && (grant_vld == (|grant_oh))); // R2
    AST_WORK_KEEP: assert property (@(posedge clk) disable iff (rst)
        (|(thr_ready & ~thr_stall)) |-> grant_vld); // R2
    AST_NO_STALLED: assert property (@(posedge clk) disable iff (rst)
        grant_vld |-> (thr_ready[grant_idx] && !thr_stall[grant_idx])); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !grant_vld |-> (grant_idx == '0)); // R8

endmodule

// File: tb/test_thread_issue_sel.sv
module test_thread_issue_sel;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  thr_ready = '0;
    logic [N-1:0]  thr_stall = '0;
    logic          cfg_wr = 1'b0;
    logic          cfg_mode = 1'b0;
    logic [IW-1:0] cfg_pref = '0;
    logic [N-1:0]  grant_oh;
    logic [IW-1:0] grant_idx;
    logic          grant_vld;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thread_issue_sel #(.N_THR(N)) i_thread_issue_sel (
        .clk(clk), .rst(rst), .thr_ready(thr_ready), .thr_stall(thr_stall),
        .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_pref(cfg_pref),
        .grant_oh(grant_oh), .grant_idx(grant_idx), .grant_vld(grant_vld)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic expect_grant(string tag, logic ev, int ei);
        logic [N-1:0]  eo;
        logic [IW-1:0] eidx;
        eo   = ev ? (N'(1) << ei) : '0;
        eidx = ev ? ei[IW-1:0] : '0;
        n_chk++;
        if (grant_vld !== ev || grant_oh !== eo || grant_idx !== eidx) begin
            n_fail++;
            $display("FAIL %s: actual vld=%0b oh=%b idx=%0d expected vld=%0b oh=%b idx=%0d",
                     tag, grant_vld, grant_oh, grant_idx, ev, eo, eidx);
        end
    endtask

    // drive inputs at the falling edge, look at outputs 1 time unit later
    task automatic step(logic [N-1:0] rdy, logic [N-1:0] stl);
        @(negedge clk);
        thr_ready = rdy;
        thr_stall = stl;
        cfg_wr    = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_wr = 1'b0; thr_ready = '0; thr_stall = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        step(4'b1111, 4'b0000);
        expect_grant("R1 first grant after reset", 1'b1, 0);
    endtask

    task automatic t_rotate();
        int seq [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
        do_reset();
        foreach (seq[i]) begin
            step(4'b1111, 4'b0000);
            expect_grant((seq[i] == 0 && i > 0) ? "R10 wrap to thread 0" : "R4 rotation order",
                         1'b1, seq[i]);
        end
    endtask

    task automatic t_skip();
        int seq_a [4] = '{0, 1, 3, 0};
        int seq_b [4] = '{1, 2, 1, 2};
        do_reset();
        foreach (seq_a[i]) begin
            step(4'b1111, 4'b0100);
            expect_grant("R3 stalled thread 2 skipped", 1'b1, seq_a[i]);
        end
        foreach (seq_b[i]) begin
            step(4'b0111, 4'b0001);
            expect_grant("R3 not-ready 3 and stalled 0 skipped", 1'b1, seq_b[i]);
        end
    endtask

    task automatic t_all_stalled();
        do_reset();
        step(4'b1111, 4'b0000);
        expect_grant("R4 grant before idle", 1'b1, 0);
        step(4'b1111, 4'b1111);
        expect_grant("R8 all stalled gives no grant", 1'b0, 0);
        step(4'b0000, 4'b0000);
        expect_grant("R2 none ready gives no grant", 1'b0, 0);
        step(4'b1111, 4'b0000);
        expect_grant("R8 pointer held across idle", 1'b1, 1);
    endtask

    task automatic t_fair();
        logic [15:0] lfsr = 16'hACE1;
        int wait_cnt = 0;
        int worst = 0;
        logic [N-1:0] rdy;
        logic [N-1:0] stl;
        do_reset();
        for (int c = 0; c < 400; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rdy = lfsr[3:0] | 4'b0100;
            stl = lfsr[7:4] & 4'b1011;
            step(rdy, stl);
            n_chk++;
            if (!grant_vld || !rdy[grant_idx] || stl[grant_idx]) begin
                n_fail++;
                $display("FAIL R3 grant on ineligible: actual idx=%0d vld=%0b expected eligible of rdy=%b stl=%b",
                         grant_idx, grant_vld, rdy, stl);
            end
            if (grant_idx == 2) wait_cnt = 0;
            else wait_cnt++;
            if (wait_cnt > worst) worst = wait_cnt;
        end
        n_chk++;
        if (worst > N - 1) begin
            n_fail++;
            $display("FAIL R5 longest wait: actual=%0d expected<=%0d", worst, N - 1);
        end
    endtask

    task automatic t_prefer();
        int seq_s [4] = '{3, 0, 1, 3};
        do_reset();
        @(negedge clk);
        thr_ready = 4'b1111; thr_stall = 4'b0000;
        cfg_wr = 1'b1; cfg_mode = 1'b1; cfg_pref = 2'd2;
        #1;
        expect_grant("R9 write cycle uses old policy", 1'b1, 0);
        for (int i = 0; i < 3; i++) begin
            step(4'b1111, 4'b0000);
            expect_grant("R6 favoured thread wins", 1'b1, 2);
        end
        foreach (seq_s[i]) begin
            step(4'b1111, 4'b0100);
            expect_grant("R7 others rotate while favourite stalls", 1'b1, seq_s[i]);
        end
        step(4'b1111, 4'b0000);
        expect_grant("R6 favourite resumes", 1'b1, 2);
        @(negedge clk);
        thr_ready = 4'b1111; thr_stall = 4'b0000;
        cfg_wr = 1'b1; cfg_mode = 1'b0; cfg_pref = 2'd0;
        #1;
        expect_grant("R9 old favoured policy during write", 1'b1, 2);
        step(4'b1111, 4'b0000);
        expect_grant("R9 rotation after write", 1'b1, 3);
        step(4'b1111, 4'b0000);
        expect_grant("R5 favourite yields in rotation", 1'b1, 0);
    endtask

    initial begin
        t_reset();
        t_rotate();
        t_skip();
        t_all_stalled();
        t_fair();
        t_prefer();
        summary();
        $finish;
    end

endmodule